// File: doc/BRIEF.md
# Layered Sprite Pixel Compositor

This block works out the colour of each screen pixel directly from the raster coordinate being drawn, with no frame store. A set of layers is evaluated in parallel for every pixel. Each layer is a filled rectangle of fixed colour or a small bitmap held in on-chip ROM. A layer reports whether the current pixel falls inside it and, if so, which colour it shows there. A priority arbiter takes the nearest reporting layer, so nearer layers hide farther ones. Where no layer covers the pixel, a fixed background colour is used.

One top-level layer is itself a group of three parts: a bitmap head, a solid arm and a solid torso. The parts are resolved by a second arbiter inside the group. The group sits at a base position given on the ports. An animation offset, also on the ports, shifts the head and the arm within the group but leaves the torso in place. The other layers are a red square, a standalone bitmap and a large blue backdrop, all at positions set by parameter.

Top module: `spc_compositor`

## Requirements
- R1: While reset is held, red, green and blue all read 0.
- R2: The colour for the coordinate and position inputs presented in one cycle appears on the outputs two clock cycles later, and new inputs may be given every cycle.
- R3: A rectangle with top-left (L,T) and size W×H covers pixel (x,y) exactly when L ≤ x < L+W and T ≤ y < T+H. The left and top edges are inside and the right and bottom edges are outside.
- R4: A bitmap of width W with top-left (L,T) reads texel address a = (y−T)·W + (x−L). The texel colour is red = a mod 256, green = 255 − (a mod 256), and blue is a per-bitmap constant: 0x11 for the group head and 0xC0 for the standalone bitmap.
- R5: Top-level layers are ranked by index, with the lowest index nearest: 0 is the group, 1 is the red square 0xFF0000 at (40,40) of size 16×16, 2 is the bitmap 6×5 at (52,50), and 3 is the blue backdrop 0x0000FF at (0,0) of size 80×60. The nearest covering layer supplies the colour.
- R6: When no layer covers the pixel, the output is the background colour 0x202020.
- R7: Inside the group the head (6×5 bitmap) is nearest, then the arm (yellow 0xFFFF00, 2×6), then the torso (green 0x00FF00, 8×10). The group covers a pixel when any of its parts does.
- R8: With base (bx,by) and animation offset (ax,ay), the head sits at (bx+ax, by+ay) and the arm at (bx+ax+6, by+ay+5). The torso stays at (bx, by+5) whatever the offset.
- R9: Changing the group base position moves all three parts by the same amount.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pix_x | input | 10 | Current raster column |
| pix_y | input | 10 | Current raster row |
| grp_x | input | 10 | Group base left position |
| grp_y | input | 10 | Group base top position |
| anim_x | input | 4 | Horizontal animation offset for the head and arm |
| anim_y | input | 4 | Vertical animation offset for the head and arm |
| red | output | 8 | Red channel of the composited pixel |
| green | output | 8 | Green channel of the composited pixel |
| blue | output | 8 | Blue channel of the composited pixel |

## Verification
The checker relies on the coordinate and position inputs being driven to known values from reset onward. The output-hold property assumes that a pixel colour depends only on the inputs from two cycles earlier and on nothing else. The bench drives every input before reset is released and changes inputs only at falling clock edges, so each comparison sees inputs that were settled. The group base is placed far from the fixed layers unless a scenario needs the two to overlap, so each check has one known nearest layer.

// File: rtl/spc_pkg.sv
`timescale 1ns/1ps
package spc_pkg;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  // Computed bitmap content: red ramps with address, green is its complement.
  function automatic rgb_t texel(input logic [31:0] addr, input logic [7:0] tint);
    rgb_t t;
    t.r = addr[7:0];
    t.g = 8'hFF - addr[7:0];
    t.b = tint;
    return t;
  endfunction

endpackage

// File: rtl/spc_region.sv
`timescale 1ns/1ps
module spc_region #(
  parameter int XW = 10,
  parameter int YW = 10,
  parameter int WD = 8,
  parameter int HT = 8
) (
  input  logic [XW-1:0] pix_x,
  input  logic [YW-1:0] pix_y,
  input  logic [XW:0]   left,
  input  logic [YW:0]   top,
  output logic          hit
);
  localparam int XE = XW + 2;
  localparam int YE = YW + 2;

  logic [XE-1:0] x_e, l_e, r_e;
  logic [YE-1:0] y_e, t_e, b_e;

  always_comb begin
    x_e = XE'(pix_x);
    l_e = XE'(left);
    r_e = l_e + XE'(WD);
    y_e = YE'(pix_y);
    t_e = YE'(top);
    b_e = t_e + YE'(HT);
    hit = (x_e >= l_e) && (x_e < r_e) && (y_e >= t_e) && (y_e < b_e);
  end
endmodule

// File: rtl/spc_solid_layer.sv
`timescale 1ns/1ps
module spc_solid_layer
  import spc_pkg::*;
#(
  parameter int          XW    = 10,
  parameter int          YW    = 10,
  parameter int          WD    = 8,
  parameter int          HT    = 8,
  parameter logic [23:0] COLOR = 24'hFFFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [XW-1:0] pix_x,
  input  logic [YW-1:0] pix_y,
  input  logic [XW:0]   left,
  input  logic [YW:0]   top,
  output logic          vld,
  output rgb_t          col
);
  logic hit_d;
  logic vld_q;

  spc_region #(.XW(XW), .YW(YW), .WD(WD), .HT(HT)) region_i (
    .pix_x (pix_x),
    .pix_y (pix_y),
    .left  (left),
    .top   (top),
    .hit   (hit_d)
  );

  // Delay the hit by one cycle so solid layers line up with bitmap reads.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= hit_d;
  end

  assign vld = vld_q;
  assign col = rgb_t'(COLOR);
endmodule

// File: rtl/spc_bitmap_layer.sv
`timescale 1ns/1ps
module spc_bitmap_layer
  import spc_pkg::*;
#(
  parameter int         XW   = 10,
  parameter int         YW   = 10,
  parameter int         WD   = 6,
  parameter int         HT   = 5,
  parameter logic [7:0] TINT = 8'h80
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [XW-1:0] pix_x,
  input  logic [YW-1:0] pix_y,
  input  logic [XW:0]   left,
  input  logic [YW:0]   top,
  output logic          vld,
  output rgb_t          col
);
  localparam int DEPTH = WD * HT;
  localparam int ADW   = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CLW   = (WD > 1) ? $clog2(WD) : 1;
  localparam int RWW   = (HT > 1) ? $clog2(HT) : 1;

  logic           hit_d;
  logic [CLW-1:0] col_idx;
  logic [RWW-1:0] row_idx;
  logic [ADW-1:0] addr_d;
  logic           vld_q;
  rgb_t           data_q;
  rgb_t           data_d;

  spc_region #(.XW(XW), .YW(YW), .WD(WD), .HT(HT)) region_i (
    .pix_x (pix_x),
    .pix_y (pix_y),
    .left  (left),
    .top   (top),
    .hit   (hit_d)
  );

  always_comb begin
    col_idx = CLW'((XW+1)'(pix_x) - left);
    row_idx = RWW'((YW+1)'(pix_y) - top);
    addr_d  = ADW'(row_idx) * ADW'(WD) + ADW'(col_idx);
    data_d  = texel(32'(addr_d), TINT);
  end

  // ROM read: data register carries no reset, valid does.
  always_ff @(posedge clk) begin
    data_q <= data_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= hit_d;
  end

  assign vld = vld_q;
  assign col = data_q;
endmodule

// File: rtl/spc_prio_arb.sv
`timescale 1ns/1ps
module spc_prio_arb
  import spc_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0] vld,
  input  rgb_t [N-1:0] col_in,
  output logic [N-1:0] grant,
  output rgb_t         col_out
);
  // Scan from the farthest layer to the nearest so the nearest valid one stays.
  always_comb begin
    grant   = '0;
    col_out = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vld[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
        col_out  = col_in[i];
      end
    end
  end
endmodule

// File: rtl/spc_group.sv
`timescale 1ns/1ps
module spc_group
  import spc_pkg::*;
#(
  parameter int XW      = 10,
  parameter int YW      = 10,
  parameter int AW      = 4,
  parameter int HEAD_W  = 6,
  parameter int HEAD_H  = 5,
  parameter int ARM_W   = 2,
  parameter int ARM_H   = 6,
  parameter int TORSO_W = 8,
  parameter int TORSO_H = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [XW-1:0] pix_x,
  input  logic [YW-1:0] pix_y,
  input  logic [XW-1:0] base_x,
  input  logic [YW-1:0] base_y,
  input  logic [AW-1:0] anim_x,
  input  logic [AW-1:0] anim_y,
  output logic          vld,
  output rgb_t          col
);
  localparam int NPART = 3;

  logic [XW:0] head_l, arm_l, torso_l;
  logic [YW:0] head_t, arm_t, torso_t;

  logic [NPART-1:0] part_vld;
  rgb_t [NPART-1:0] part_col;
  logic [NPART-1:0] part_grant;

  always_comb begin
    head_l  = (XW+1)'(base_x) + (XW+1)'(anim_x);
    head_t  = (YW+1)'(base_y) + (YW+1)'(anim_y);
    arm_l   = head_l + (XW+1)'(HEAD_W);
    arm_t   = head_t + (YW+1)'(HEAD_H);
    torso_l = (XW+1)'(base_x);
    torso_t = (YW+1)'(base_y) + (YW+1)'(HEAD_H);
  end

  spc_bitmap_layer #(.XW(XW), .YW(YW), .WD(HEAD_W), .HT(HEAD_H), .TINT(8'h11)) head_i (
    .clk (clk), .rst_n (rst_n), .pix_x (pix_x), .pix_y (pix_y),
    .left (head_l), .top (head_t), .vld (part_vld[0]), .col (part_col[0])
  );

  spc_solid_layer #(.XW(XW), .YW(YW), .WD(ARM_W), .HT(ARM_H), .COLOR(24'hFFFF00)) arm_i (
    .clk (clk), .rst_n (rst_n), .pix_x (pix_x), .pix_y (pix_y),
    .left (arm_l), .top (arm_t), .vld (part_vld[1]), .col (part_col[1])
  );

  spc_solid_layer #(.XW(XW), .YW(YW), .WD(TORSO_W), .HT(TORSO_H), .COLOR(24'h00FF00)) torso_i (
    .clk (clk), .rst_n (rst_n), .pix_x (pix_x), .pix_y (pix_y),
    .left (torso_l), .top (torso_t), .vld (part_vld[2]), .col (part_col[2])
  );

  spc_prio_arb #(.N(NPART)) part_arb_i (
    .vld     (part_vld),
    .col_in  (part_col),
    .grant   (part_grant),
    .col_out (col)
  );

  assign vld = |part_grant;
endmodule

// File: rtl/spc_compositor.sv
`timescale 1ns/1ps
module spc_compositor
  import spc_pkg::*;
#(
  parameter int          XW     = 10,
  parameter int          YW     = 10,
  parameter int          AW     = 4,
  parameter logic [23:0] BG     = 24'h202020,
  parameter int          SQ_X   = 40,
  parameter int          SQ_Y   = 40,
  parameter int          SQ_W   = 16,
  parameter int          SQ_H   = 16,
  parameter int          BM_X   = 52,
  parameter int          BM_Y   = 50,
  parameter int          BM_W   = 6,
  parameter int          BM_H   = 5,
  parameter int          BD_W   = 80,
  parameter int          BD_H   = 60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [XW-1:0] pix_x,
  input  logic [YW-1:0] pix_y,
  input  logic [XW-1:0] grp_x,
  input  logic [YW-1:0] grp_y,
  input  logic [AW-1:0] anim_x,
  input  logic [AW-1:0] anim_y,
  output logic [7:0]    red,
  output logic [7:0]    green,
  output logic [7:0]    blue
);
  localparam int NLAY = 4;

  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic [NLAY-1:0] lay_vld;
  rgb_t [NLAY-1:0] lay_col;
  logic [NLAY-1:0] grant;
  rgb_t            win_col;
  rgb_t            out_d;
  rgb_t            out_q;

  // Reset: asserted at once, released after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  spc_group #(.XW(XW), .YW(YW), .AW(AW)) group_i (
    .clk (clk), .rst_n (rst_int_n), .pix_x (pix_x), .pix_y (pix_y),
    .base_x (grp_x), .base_y (grp_y), .anim_x (anim_x), .anim_y (anim_y),
    .vld (lay_vld[0]), .col (lay_col[0])
  );

  spc_solid_layer #(.XW(XW), .YW(YW), .WD(SQ_W), .HT(SQ_H), .COLOR(24'hFF0000)) square_i (
    .clk (clk), .rst_n (rst_int_n), .pix_x (pix_x), .pix_y (pix_y),
    .left ((XW+1)'(SQ_X)), .top ((YW+1)'(SQ_Y)), .vld (lay_vld[1]), .col (lay_col[1])
  );

  spc_bitmap_layer #(.XW(XW), .YW(YW), .WD(BM_W), .HT(BM_H), .TINT(8'hC0)) bitmap_i (
    .clk (clk), .rst_n (rst_int_n), .pix_x (pix_x), .pix_y (pix_y),
    .left ((XW+1)'(BM_X)), .top ((YW+1)'(BM_Y)), .vld (lay_vld[2]), .col (lay_col[2])
  );

  spc_solid_layer #(.XW(XW), .YW(YW), .WD(BD_W), .HT(BD_H), .COLOR(24'h0000FF)) backdrop_i (
    .clk (clk), .rst_n (rst_int_n), .pix_x (pix_x), .pix_y (pix_y),
    .left ('0), .top ('0), .vld (lay_vld[3]), .col (lay_col[3])
  );

  spc_prio_arb #(.N(NLAY)) top_arb_i (
    .vld     (lay_vld),
    .col_in  (lay_col),
    .grant   (grant),
    .col_out (win_col)
  );

  always_comb begin
    out_d = (|grant) ? win_col : rgb_t'(BG);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) out_q <= '0;
    else            out_q <= out_d;
  end

  assign red   = out_q.r;
  assign green = out_q.g;
  assign blue  = out_q.b;
endmodule

// File: rtl/spc_compositor_chk.sv
`timescale 1ns/1ps
module spc_compositor_chk #(
  parameter int          XW   = 10,
  parameter int          YW   = 10,
  parameter int          AW   = 4,
  parameter int          NLAY = 4,
  parameter logic [23:0] BG   = 24'h202020,
  parameter int          BD_W = 80,
  parameter int          BD_H = 60
) (
  input logic            clk,
  input logic            rst_int_n,
  input logic [XW-1:0]   pix_x,
  input logic [YW-1:0]   pix_y,
  input logic [XW-1:0]   grp_x,
  input logic [YW-1:0]   grp_y,
  input logic [AW-1:0]   anim_x,
  input logic [AW-1:0]   anim_y,
  input logic [NLAY-1:0] lay_vld,
  input logic [NLAY-1:0] grant,
  input logic [7:0]      red,
  input logic [7:0]      green,
  input logic [7:0]      blue
);
  logic [1:0] age_q;
  logic [2*XW+2*YW+2*AW-1:0] in_bus;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)        age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  assign in_bus = {pix_x, pix_y, grp_x, grp_y, anim_x, anim_y};

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(grant)) else $error("grant not one-hot"); // R5

  AST_GRANT_NEAREST: assert property (@(posedge clk) disable iff (!rst_int_n)
    ((grant & ~lay_vld) == '0) && (lay_vld[0] -> grant[0])) else $error("grant skips nearest"); // R5

  AST_BG_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_int_n)
    (age_q != 2'd0) && ($past(lay_vld) == '0) |-> ({red, green, blue} == BG)) else $error("background wrong"); // R6

  AST_BACKDROP_BOUNDS: assert property (@(posedge clk) disable iff (!rst_int_n)
    (age_q != 2'd0) && lay_vld[NLAY-1] |-> (32'($past(pix_x)) < BD_W) && (32'($past(pix_y)) < BD_H)) else $error("backdrop edge"); // R3

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_int_n)
    (age_q == 2'd3) && ($past(in_bus, 2) == $past(in_bus, 3)) |-> $stable({red, green, blue})) else $error("output not held"); // R2
endmodule

bind spc_compositor spc_compositor_chk #(
  .XW(XW), .YW(YW), .AW(AW), .NLAY(4), .BG(BG), .BD_W(BD_W), .BD_H(BD_H)
) chk_i (
  .clk (clk), .rst_int_n (rst_int_n), .pix_x (pix_x), .pix_y (pix_y),
  .grp_x (grp_x), .grp_y (grp_y), .anim_x (anim_x), .anim_y (anim_y),
  .lay_vld (lay_vld), .grant (grant), .red (red), .green (green), .blue (blue)
);

// File: tb/spc_compositor_tb_top.sv
`timescale 1ns/1ps
module spc_compositor_tb_top;
  logic       clk;
  logic       rst_n;
  logic [9:0] pix_x, pix_y, grp_x, grp_y;
  logic [3:0] anim_x, anim_y;
  logic [7:0] red, green, blue;

  int n_checks = 0;
  int n_fail   = 0;

  spc_compositor dut_i (
    .clk (clk), .rst_n (rst_n), .pix_x (pix_x), .pix_y (pix_y),
    .grp_x (grp_x), .grp_y (grp_y), .anim_x (anim_x), .anim_y (anim_y),
    .red (red), .green (green), .blue (blue)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [23:0] tex(int a, logic [7:0] tint);
    return {8'(a), 8'(255 - (a % 256)), tint};
  endfunction

  function automatic bit inside_r(int x, int y, int l, int t, int w, int h);
    return (x >= l) && (x < l + w) && (y >= t) && (y < t + h);
  endfunction

  // Expected colour from the requirements (R3..R9).
  function automatic logic [23:0] model(int x, int y, int gx, int gy, int ax, int ay);
    int hx = gx + ax;
    int hy = gy + ay;
    if (inside_r(x, y, hx, hy, 6, 5))          return tex((y - hy) * 6 + (x - hx), 8'h11);
    if (inside_r(x, y, hx + 6, hy + 5, 2, 6))  return 24'hFFFF00;
    if (inside_r(x, y, gx, gy + 5, 8, 10))     return 24'h00FF00;
    if (inside_r(x, y, 40, 40, 16, 16))        return 24'hFF0000;
    if (inside_r(x, y, 52, 50, 6, 5))          return tex((y - 50) * 6 + (x - 52), 8'hC0);
    if (inside_r(x, y, 0, 0, 80, 60))          return 24'h0000FF;
    return 24'h202020;
  endfunction

  task automatic check(string req, logic [23:0] exp);
    n_checks++;
    if ({red, green, blue} !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %06h expected %06h", req, {red, green, blue}, exp);
    end
  endtask

  task automatic set_group(int gx, int gy, int ax, int ay);
    @(negedge clk);
    grp_x = 10'(gx); grp_y = 10'(gy); anim_x = 4'(ax); anim_y = 4'(ay);
  endtask

  // Drive one pixel, wait for two rising edges, sample at the falling edge.
  task automatic probe(string req, int x, int y, logic [23:0] exp);
    @(negedge clk);
    pix_x = 10'(x); pix_y = 10'(y);
    @(negedge clk);
    @(negedge clk);
    check(req, exp);
    check({req, " model"}, model(x, y, int'(grp_x), int'(grp_y), int'(anim_x), int'(anim_y)));
  endtask

  task automatic t_reset;
    rst_n = 1'b1;
    pix_x = 10'd100; pix_y = 10'd100;
    grp_x = 10'd300; grp_y = 10'd300; anim_x = '0; anim_y = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset", 24'h000000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_background;
    probe("R6 far", 100, 100, 24'h202020);
    probe("R3 right edge out", 80, 10, 24'h202020);
    probe("R3 right edge in", 79, 10, 24'h0000FF);
    probe("R3 bottom edge out", 5, 60, 24'h202020);
  endtask

  task automatic t_solid_edges;
    probe("R3 top-left in", 40, 40, 24'hFF0000);
    probe("R3 bottom-right in", 55, 55, 24'hFF0000);
    probe("R3 left out", 39, 40, 24'h0000FF);
    probe("R3 right out", 56, 40, 24'h0000FF);
  endtask

  task automatic t_bitmap;
    probe("R4 texel 4", 56, 50, 24'h04FBC0);
    probe("R4 texel 29", 57, 54, 24'h1DE2C0);
    probe("R4 row stride", 56, 51, 24'h0AF5C0);
    probe("R4 past edge", 58, 54, 24'h0000FF);
    probe("R5 square over bitmap", 53, 51, 24'hFF0000);
  endtask

  task automatic t_group_parts;
    set_group(10, 10, 0, 0);
    probe("R7 head texel 0", 10, 10, 24'h00FF11);
    probe("R7 arm over torso", 16, 15, 24'hFFFF00);
    probe("R7 torso", 12, 16, 24'h00FF00);
    set_group(10, 10, 0, 3);
    probe("R8 head moved over torso", 12, 16, 24'h14EB11);
    probe("R8 torso fixed bottom", 10, 24, 24'h00FF00);
    probe("R8 torso fixed below", 10, 25, 24'h0000FF);
    set_group(10, 10, 2, 0);
    probe("R8 arm moved", 18, 15, 24'hFFFF00);
    probe("R8 arm left vacated", 16, 15, 24'h00FF00);
  endtask

  task automatic t_base;
    set_group(20, 5, 0, 0);
    probe("R9 head at base", 20, 5, 24'h00FF11);
    probe("R9 left of base", 19, 5, 24'h0000FF);
    probe("R9 torso moved", 27, 19, 24'h00FF00);
    set_group(40, 40, 0, 0);
    probe("R5 group over square", 41, 41, 24'h07F811);
  endtask

  // Back-to-back pixels: each result two cycles after its coordinate.
  task automatic t_stream;
    set_group(300, 300, 0, 0);
    @(negedge clk);
    pix_y = 10'd50;
    for (int i = 0; i < 26; i++) begin
      @(negedge clk);
      if (i >= 2) check("R2 stream", model(36 + i - 2, 50, 300, 300, 0, 0));
      if (i < 24) pix_x = 10'(36 + i);
    end
  endtask

  initial begin
    #(200000 * 8);
    n_fail++;
    n_checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    t_reset();
    t_background();
    t_solid_edges();
    t_bitmap();
    t_group_parts();
    t_base();
    t_stream();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule